// File: doc/BRIEF.md
# Circular Buffer Index Address Unit

This block serves load/store address generation for circular-buffer accesses. It takes a base address, a packed companion word and a signed 10-bit step. The companion word holds the buffer length in its upper half and the current index in its lower half. From these the block forms the effective address of the access from the current index. It also forms the stepped index, wrapped back into the buffer, and returns it inside a refreshed companion word that the register file can write back.

The memory access and the register file are outside the block. A request is presented with `req_valid` for one cycle. One cycle later the registered results appear with `rsp_valid`. The result registers keep their last values while no request is presented.

A small two-state sequencer paces the output. In `ST_IDLE`, with no request, the transition `IDLE->IDLE` keeps the sequencer idle and `IDLE->EMIT` is taken on a request. In `ST_EMIT`, the cycle after a request, the transition `EMIT->EMIT` is taken on a back-to-back request and `EMIT->IDLE` is taken otherwise. `rsp_valid` is high exactly in `ST_EMIT`.

The wrap uses a single conditional add or subtract of the length, so it is exact under three assumptions. The length must be non-zero, the current index must be below the length, and the magnitude of the step must not exceed the length.

Top module: `circ_idx_unit`

## Requirements
- R1: `rsp_valid` is 0 in reset and rises exactly one clock after a cycle with `req_valid`=1. It is 0 one clock after a cycle with `req_valid`=0. All outputs reset to 0.
- R2: `rsp_addr` equals `req_base` plus the zero-extended index `req_ctx[15:0]`, modulo 2^32. The pre-update index is used.
- R3: Candidate = index + sign-extended `req_step` (signed). A negative candidate yields new index = candidate + length, where length is `req_ctx[31:16]`.
- R4: A non-negative candidate yields new index = candidate modulo length. This holds for steps whose magnitude equals the length, such as step = +length.
- R5: `rsp_ctx[31:16]` equals the request's length and `rsp_ctx[15:0]` equals the new index.
- R6: With length 0, the new index is 0 and `rsp_len_zero`=1. With a non-zero length, `rsp_len_zero`=0.
- R7: After a cycle with `req_valid`=0, `rsp_addr`, `rsp_ctx` and `rsp_len_zero` keep their previous values.
- R8: Under the stated assumptions, the returned index is below the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_base | input | 32 | Buffer base address |
| req_ctx | input | 32 | {length, index} companion word |
| req_step | input | 10 | Signed index step |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_addr | output | 32 | Effective address |
| rsp_ctx | output | 32 | Refreshed {length, new index} |
| rsp_len_zero | output | 1 | Degenerate zero-length buffer flag |

## Verification
A wrong sequencer state shows at the ports one clock later as a missing or extra `rsp_valid`. A wrong wrap decision shows in the same response as an index that is off by exactly one length, or that lies outside the buffer. A result register that loads while idle shows in the first idle cycle, because the held address or companion word then changes. The bench compares every output on every clock against a behavioural model. The directed cases cover a forward step past the buffer end, a backward step below zero, steps of plus and minus the length, a zero length, and address overflow.

// File: rtl/circ_idx_pkg.sv
package circ_idx_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;
endpackage

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] ea
);
    localparam int PAD_W = ADDR_W - IDX_W;

    // R2: base plus zero-extended pre-update index
    always_comb begin
        ea = base + {{PAD_W{1'b0}}, idx};
    end
endmodule

// File: rtl/circ_wrap.sv
module circ_wrap #(
    parameter int IDX_W = 16,
    parameter int OFF_W = 10
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] len,
    input  logic [OFF_W-1:0] step,
    output logic [IDX_W-1:0] new_idx,
    output logic             len_zero
);
    localparam int CW = IDX_W + 2;

    logic [CW-1:0] idx_e, len_e, step_e, cand, cand_add, cand_sub;
    logic          cand_neg, cand_ge;

    always_comb begin
        idx_e    = {2'b00, idx};
        len_e    = {2'b00, len};
        step_e   = {{(CW-OFF_W){step[OFF_W-1]}}, step};
        cand     = idx_e + step_e;
        cand_neg = cand[CW-1];
        cand_add = cand + len_e;
        cand_sub = cand - len_e;
        cand_ge  = !cand_neg && (cand >= len_e);
        len_zero = (len == '0);
        if (len_zero) begin
            new_idx = '0;                       // R6
        end else if (cand_neg) begin
            new_idx = cand_add[IDX_W-1:0];      // R3
        end else if (cand_ge) begin
            new_idx = cand_sub[IDX_W-1:0];      // R4
        end else begin
            new_idx = cand[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/circ_idx_unit.sv
module circ_idx_unit
    import circ_idx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int OFF_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [2*IDX_W-1:0]   req_ctx,
    input  logic [OFF_W-1:0]     req_step,
    output logic                 rsp_valid,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic [2*IDX_W-1:0]   rsp_ctx,
    output logic                 rsp_len_zero
);
    localparam int CTX_W = 2 * IDX_W;

    emit_state_t state_q, state_d;

    logic [IDX_W-1:0]  cur_idx, cur_len, nxt_idx;
    logic [ADDR_W-1:0] ea_c;
    logic              len_zero_c;

    assign cur_idx = req_ctx[IDX_W-1:0];
    assign cur_len = req_ctx[CTX_W-1:IDX_W];

    circ_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .base (req_base),
        .idx  (cur_idx),
        .ea   (ea_c)
    );

    circ_wrap #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_wrap (
        .idx      (cur_idx),
        .len      (cur_len),
        .step     (req_step),
        .new_idx  (nxt_idx),
        .len_zero (len_zero_c)
    );

    // sequencer: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    assign rsp_valid = (state_q == ST_EMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr     <= '0;
            rsp_ctx      <= '0;
            rsp_len_zero <= 1'b0;
        end else if (req_valid) begin
            rsp_addr     <= ea_c;
            rsp_ctx      <= {cur_len, nxt_idx};
            rsp_len_zero <= len_zero_c;
        end
    end

    // checks
    logic [OFF_W-1:0] step_neg;
    logic [IDX_W:0]   step_mag;
    logic             in_contract;
    assign step_neg    = -req_step;
    assign step_mag    = req_step[OFF_W-1] ? {{(IDX_W+1-OFF_W){1'b0}}, step_neg}
                                           : {{(IDX_W+1-OFF_W){1'b0}}, req_step};
    assign in_contract = (cur_len != '0) && (cur_idx < cur_len) && (step_mag <= {1'b0, cur_len});

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r5_len_carried: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ctx[CTX_W-1:IDX_W] == $past(cur_len));
    a_r6_zero_len_idx: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_len_zero |-> rsp_ctx[IDX_W-1:0] == '0);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_addr) && $stable(rsp_ctx) && $stable(rsp_len_zero));
    a_r8_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && in_contract |=> rsp_ctx[IDX_W-1:0] < rsp_ctx[CTX_W-1:IDX_W]);
endmodule

// File: tb/circ_idx_unit_tb_top.sv
module circ_idx_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_base = '0;
    logic [31:0] req_ctx = '0;
    logic [9:0]  req_step = '0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [31:0] rsp_ctx;
    logic        rsp_len_zero;

    always #2.5 clk = ~clk;

    circ_idx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_ctx(req_ctx), .req_step(req_step), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_ctx(rsp_ctx), .rsp_len_zero(rsp_len_zero)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model of registered outputs
    bit          m_valid = 0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_ctx = '0;
    bit          m_err = 0;
    string       m_idx_tag = "R1";
    bit          m_idle = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1 valid", {31'b0, rsp_valid}, {31'b0, m_valid});
        chk(m_idle ? "R7 addr hold" : "R2 addr", rsp_addr, m_addr);
        chk(m_idle ? "R7 ctx hold" : "R5 ctx length", {16'b0, rsp_ctx[31:16]}, {16'b0, m_ctx[31:16]});
        chk(m_idle ? "R7 idx hold" : m_idx_tag, {16'b0, rsp_ctx[15:0]}, {16'b0, m_ctx[15:0]});
        chk(m_idle ? "R7 err hold" : "R6 flag", {31'b0, rsp_len_zero}, {31'b0, m_err});
    endtask

    task automatic step(input bit v, input logic [31:0] base, input int len,
                        input int idx, input int off);
        int cand, nidx;
        @(negedge clk);
        compare();
        req_valid = v;
        req_base  = base;
        req_ctx   = {len[15:0], idx[15:0]};
        req_step  = off[9:0];
        m_valid   = v;
        m_idle    = !v;
        if (v) begin
            cand = idx + off;
            if (len == 0) begin
                nidx = 0; m_idx_tag = "R6 idx";
            end else if (cand < 0) begin
                nidx = cand + len; m_idx_tag = "R3 idx";
            end else begin
                nidx = cand % len; m_idx_tag = "R4 idx";
            end
            m_addr = base + 32'(idx);
            m_ctx  = {len[15:0], nidx[15:0]};
            m_err  = (len == 0);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();                      // R1 reset state all zero
        rst_n = 1'b1;
        step(1, 32'h1000_0000, 8, 6, 3);      // R4 forward past end -> 1
        step(1, 32'h1000_0000, 8, 1, -3);     // R3 backward below zero -> 6
        step(1, 32'h2000_0000, 8, 3, 8);      // R4 step = +length -> 3
        step(1, 32'h2000_0000, 8, 3, -8);     // R3 step = -length -> 3
        step(1, 32'h2000_0000, 8, 0, -8);     // R3 -> 0
        step(0, 32'hDEAD_BEEF, 5, 1, 1);      // R7 idle
        step(0, 32'h0, 0, 0, 0);              // R7 idle, R1 low
        step(1, 32'h3000_0000, 0, 4, 2);      // R6 zero length
        step(1, 32'h3000_0000, 100, 99, 0);   // R4 no move
        step(1, 32'hFFFF_FFF0, 512, 32, 1);   // R2 address wrap
        step(1, 32'h4000_0000, 65535, 65534, 511); // R4 large length
        step(1, 32'h4000_0000, 1000, 5, -512);     // R3
        for (int i = 0; i < 300; i++) begin
            int len, idx, off, lim;
            len = int'($urandom_range(1, 1200));
            idx = int'($urandom_range(0, len - 1));
            lim = (len < 512) ? len : 511;
            off = int'($urandom_range(0, 2 * lim)) - lim;
            if ((i % 7) == 3) len = 0;
            step(($urandom_range(0, 3) != 0), $urandom, len, idx, off);
        end
        step(0, 32'h0, 0, 0, 0);
        step(0, 32'h0, 0, 0, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule